// File: doc/BRIEF.md
# CIP AM824 Packet Depacketizer

This block takes the payload of isochronous packets one 32-bit quadlet per cycle and turns it into audio samples and MIDI bytes. Each packet opens with two header quadlets. The first carries the sender's node number, the length of a data block in quadlets and a running block counter. The second carries a format code and a sample-rate code. Once both header quadlets pass their checks, the header fields are published. Every data block that follows is then split into slots. Slot 0 of each block is a MIDI quadlet. The slots after it carry audio for channels 0, 1, 2 and onward.

Eight MIDI ports share the single MIDI slot in turn. The port is chosen from the absolute index of the block, so the rotation continues across packet boundaries. The block counter lets the receiver spot lost packets: each new header's counter is compared with the value predicted from the previous packet. A mismatch gives a one-cycle loss pulse, and the receiver then resynchronises to the new counter. A header that fails its checks causes the whole packet to be discarded and increments a saturating error counter.

The upstream logic marks the first and the last quadlet of every packet. Isochronous framing, CRC checking and clock recovery are handled outside this block.

Top module: `cip_am824_depacketizer`

## Requirements
- R1: After reset, every valid and pulse output is low, and every header field, the sample, the channel and the header-error counter are zero.
- R2: A good header is published on the cycle after its second quadlet is accepted. The published fields are source node (bits 29:24 of quadlet 0), block size in quadlets (bits 23:16 of quadlet 0), block count (bits 7:0 of quadlet 0) and rate code (bits 18:16 of quadlet 1; codes 0 to 6 stand for 32, 44.1, 48, 88.2, 96, 176.4 and 192 kHz).
- R3: A header is good when quadlet 0 has bits 31:30 = 00 and bits 15:8 = 0, and quadlet 1 has bits 31:30 = 10 and bits 29:24 = 0x10. Otherwise the packet produces no sample or MIDI output, leaves the published header unchanged, and adds one to the header-error counter, which saturates at its maximum.
- R4: The first quadlet of each block is the MIDI slot. Label 0x81 in bits 31:24 gives a MIDI strobe one cycle later, with the byte taken from bits 23:16 and the port equal to (block count + block index within the packet) mod 8. Any other label in that slot produces nothing.
- R5: Audio slot s of a block (s = 1 to size-1) with label 0x40 gives, one cycle later, a sample strobe with channel s-1 and the 24-bit sample from bits 23:0.
- R6: An audio slot with any label other than 0x40 still gives a sample strobe on its channel, but the sample is zero and the label-error flag is high for that cycle.
- R7: The expected count of the next header is the previous good header's count plus the number of complete blocks that followed it, mod 256. A good header whose count differs gives a one-cycle loss pulse alongside its publication, and prediction restarts from that header's count. The first good header after reset never flags a loss.
- R8: A quadlet marked first always restarts header parsing, even in the middle of a packet. Quadlets that arrive outside a packet (after its last quadlet and before the next first) are ignored.
- R9: A packet made of the header alone, with its last-quadlet mark on quadlet 1, is published and predicts the next count equal to its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| qValid | input | 1 | Quadlet present this cycle |
| qFirst | input | 1 | Quadlet is the first of a packet |
| qLast | input | 1 | Quadlet is the last of a packet |
| qData | input | 32 | Payload quadlet |
| srcNode | output | 6 | Published source node |
| blkSize | output | 8 | Published block size in quadlets |
| blkCount | output | 8 | Published block count |
| rateCode | output | 3 | Published sample-rate code |
| pcmValid | output | 1 | Audio sample strobe |
| pcmChan | output | 8 | Audio channel index |
| pcmSample | output | 24 | Audio sample |
| labelErr | output | 1 | Audio slot had an unknown label |
| midiValid | output | 1 | MIDI byte strobe |
| midiPort | output | PORT_W | MIDI port index |
| midiByte | output | 8 | MIDI byte |
| lossPulse | output | 1 | Block-count discontinuity detected |
| hdrErrCount | output | HDR_ERR_W | Saturating count of rejected headers |

## Verification
A wrong slot counter appears at the ports within one block, as a wrong audio channel number or as a MIDI strobe on a slot that is not first in its block. A wrong block index appears as a wrong MIDI port on the very next block. A wrong count prediction does not show inside the packet where it goes wrong. It shows at the next header, as a missing or spurious loss pulse. For that reason the sweeps chain many packets of varying block size and length, and each packet's count follows from the one before. Header rejection shows at once: the error counter moves, and no strobes appear for the rest of that packet.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int QUAD_W   = 32;
  localparam int SAMPLE_W = 24;
  localparam int BYTE_W   = 8;
  localparam int NODE_W   = 6;
  localparam int RATE_W   = 3;

  localparam logic [7:0] LBL_PCM   = 8'h40;
  localparam logic [7:0] LBL_MIDI1 = 8'h81;
  localparam logic [5:0] FMT_AUDIO = 6'h10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR1,
    ST_DATA,
    ST_DROP
  } cip_state_t;

  // strobes from the control to the datapath, valid in the cycle a quadlet is accepted
  typedef struct packed {
    logic              hdr0Load;
    logic              commit;
    logic              hdrErr;
    logic              loss;
    logic              midiSlot;
    logic              audioSlot;
    logic [BYTE_W-1:0] chan;
    logic [BYTE_W-1:0] port;
  } cip_strobes_t;
endpackage

// File: rtl/cip_ctrl.sv
module cip_ctrl
  import cip_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              qValid,
  input  logic              qFirst,
  input  logic              qLast,
  input  logic [QUAD_W-1:0] qData,
  output cip_strobes_t      strb
);
  cip_state_t        st;
  logic [BYTE_W-1:0] dbsR;
  logic [BYTE_W-1:0] dbcR;
  logic [BYTE_W-1:0] slot;
  logic [BYTE_W-1:0] blk;
  logic [BYTE_W-1:0] expNext;
  logic              hdr0OkR;
  logic              haveRef;

  logic hdr0Good;
  logic hdr1Good;
  logic blkEnd;
  logic inBody;

  assign hdr0Good = (qData[31:30] == 2'b00) && (qData[15:8] == 8'h00);
  assign hdr1Good = hdr0OkR && (qData[31:30] == 2'b10) && (qData[29:24] == FMT_AUDIO);
  assign blkEnd   = (slot == dbsR - 8'd1);
  assign inBody   = qValid && !qFirst;

  always_comb begin
    strb          = '0;
    strb.chan     = slot - 8'd1;
    strb.port     = dbcR + blk;
    if (qValid && qFirst) begin
      strb.hdr0Load = 1'b1;
      strb.hdrErr   = qLast;
    end else if (inBody) begin
      case (st)
        ST_HDR1: begin
          if (hdr1Good) begin
            strb.commit = 1'b1;
            strb.loss   = haveRef && (dbcR != expNext);
          end else begin
            strb.hdrErr = 1'b1;
          end
        end
        ST_DATA: begin
          if (dbsR != 8'd0) begin
            strb.midiSlot  = (slot == 8'd0);
            strb.audioSlot = (slot != 8'd0);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      dbsR    <= '0;
      dbcR    <= '0;
      slot    <= '0;
      blk     <= '0;
      expNext <= '0;
      hdr0OkR <= 1'b0;
      haveRef <= 1'b0;
    end else if (qValid && qFirst) begin
      dbsR    <= qData[23:16];
      dbcR    <= qData[7:0];
      hdr0OkR <= hdr0Good;
      st      <= qLast ? ST_IDLE : ST_HDR1;
    end else if (inBody) begin
      case (st)
        ST_HDR1: begin
          if (hdr1Good) begin
            haveRef <= 1'b1;
            expNext <= dbcR;
            slot    <= '0;
            blk     <= '0;
            st      <= qLast ? ST_IDLE : ST_DATA;
          end else begin
            st      <= qLast ? ST_IDLE : ST_DROP;
          end
        end
        ST_DATA: begin
          if (dbsR != 8'd0) begin
            if (blkEnd) begin
              slot    <= '0;
              blk     <= blk + 8'd1;
              expNext <= expNext + 8'd1;
            end else begin
              slot    <= slot + 8'd1;
            end
          end
          if (qLast) st <= ST_IDLE;
        end
        ST_DROP: begin
          if (qLast) st <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  // R4, R5: the slot index never reaches the block size while a body is parsed
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_DATA && dbsR != 8'd0) |-> (slot < dbsR));

  // R8: a first-marked quadlet that does not also end the packet always leads to header parsing
  a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
    (qValid && qFirst && !qLast) |=> (st == ST_HDR1));

  // R7: prediction restarts from the count of each accepted header
  a_r7_resync: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (expNext == $past(dbcR) && haveRef));

  // R3: a rejected header never leads into the body state
  a_r3_no_body: assert property (@(posedge clk) disable iff (!rstN)
    strb.hdrErr |=> (st != ST_DATA));
endmodule

// File: rtl/cip_datapath.sv
module cip_datapath
  import cip_pkg::*;
#(
  parameter int HDR_ERR_W = 8,
  parameter int PORT_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [QUAD_W-1:0]   qData,
  input  cip_strobes_t        strb,
  output logic [NODE_W-1:0]   srcNode,
  output logic [BYTE_W-1:0]   blkSize,
  output logic [BYTE_W-1:0]   blkCount,
  output logic [RATE_W-1:0]   rateCode,
  output logic                pcmValid,
  output logic [BYTE_W-1:0]   pcmChan,
  output logic [SAMPLE_W-1:0] pcmSample,
  output logic                labelErr,
  output logic                midiValid,
  output logic [PORT_W-1:0]   midiPort,
  output logic [BYTE_W-1:0]   midiByte,
  output logic                lossPulse,
  output logic [HDR_ERR_W-1:0] hdrErrCount
);
  logic [NODE_W-1:0] stageNode;
  logic [BYTE_W-1:0] stageDbs;
  logic [BYTE_W-1:0] stageDbc;
  logic [7:0]        label;
  logic              pcmOk;

  assign label = qData[31:24];
  assign pcmOk = (label == LBL_PCM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageNode   <= '0;
      stageDbs    <= '0;
      stageDbc    <= '0;
      srcNode     <= '0;
      blkSize     <= '0;
      blkCount    <= '0;
      rateCode    <= '0;
      pcmValid    <= 1'b0;
      pcmChan     <= '0;
      pcmSample   <= '0;
      labelErr    <= 1'b0;
      midiValid   <= 1'b0;
      midiPort    <= '0;
      midiByte    <= '0;
      lossPulse   <= 1'b0;
      hdrErrCount <= '0;
    end else begin
      pcmValid  <= strb.audioSlot;
      labelErr  <= strb.audioSlot && !pcmOk;
      midiValid <= strb.midiSlot && (label == LBL_MIDI1);
      lossPulse <= strb.loss;
      if (strb.audioSlot) begin
        pcmChan   <= strb.chan;
        pcmSample <= pcmOk ? qData[SAMPLE_W-1:0] : '0;
      end
      if (strb.midiSlot && label == LBL_MIDI1) begin
        midiPort <= strb.port[PORT_W-1:0];
        midiByte <= qData[23:16];
      end
      if (strb.hdr0Load) begin
        stageNode <= qData[29:24];
        stageDbs  <= qData[23:16];
        stageDbc  <= qData[7:0];
      end
      if (strb.commit) begin
        srcNode  <= stageNode;
        blkSize  <= stageDbs;
        blkCount <= stageDbc;
        rateCode <= qData[18:16];
      end
      if (strb.hdrErr && hdrErrCount != '1) begin
        hdrErrCount <= hdrErrCount + 1'b1;
      end
    end
  end

  // R4, R5: one slot yields at most one kind of strobe
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(pcmValid && midiValid));

  // R6: a label error only comes with a zeroed sample strobe
  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    labelErr |-> (pcmValid && pcmSample == '0));

  // R7: the loss indication lasts a single cycle
  a_r7_loss_single: assert property (@(posedge clk) disable iff (!rstN)
    lossPulse |=> !lossPulse);

  // R3: the error counter only ever holds or steps by one
  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (hdrErrCount == $past(hdrErrCount) || hdrErrCount == $past(hdrErrCount) + 1'b1));

  // R2: published fields change only with a good header
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(blkCount) && $stable(blkSize) && $stable(srcNode));
endmodule

// File: rtl/cip_am824_depacketizer.sv
module cip_am824_depacketizer
  import cip_pkg::*;
#(
  parameter int HDR_ERR_W  = 8,
  parameter int MIDI_PORTS = 8,
  localparam int PORT_W    = $clog2(MIDI_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 qValid,
  input  logic                 qFirst,
  input  logic                 qLast,
  input  logic [31:0]          qData,
  output logic [5:0]           srcNode,
  output logic [7:0]           blkSize,
  output logic [7:0]           blkCount,
  output logic [2:0]           rateCode,
  output logic                 pcmValid,
  output logic [7:0]           pcmChan,
  output logic [23:0]          pcmSample,
  output logic                 labelErr,
  output logic                 midiValid,
  output logic [PORT_W-1:0]    midiPort,
  output logic [7:0]           midiByte,
  output logic                 lossPulse,
  output logic [HDR_ERR_W-1:0] hdrErrCount
);
  cip_strobes_t strb;

  cip_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .qValid (qValid),
    .qFirst (qFirst),
    .qLast  (qLast),
    .qData  (qData),
    .strb   (strb)
  );

  cip_datapath #(
    .HDR_ERR_W (HDR_ERR_W),
    .PORT_W    (PORT_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .qData       (qData),
    .strb        (strb),
    .srcNode     (srcNode),
    .blkSize     (blkSize),
    .blkCount    (blkCount),
    .rateCode    (rateCode),
    .pcmValid    (pcmValid),
    .pcmChan     (pcmChan),
    .pcmSample   (pcmSample),
    .labelErr    (labelErr),
    .midiValid   (midiValid),
    .midiPort    (midiPort),
    .midiByte    (midiByte),
    .lossPulse   (lossPulse),
    .hdrErrCount (hdrErrCount)
  );
endmodule

// File: tb/cip_am824_depacketizer_test.sv
module cip_am824_depacketizer_test;
  localparam time CLK_PERIOD = 10;
  localparam int  ERRW       = 3;
  localparam int  ERRMAX     = (1 << ERRW) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        qValid = 1'b0, qFirst = 1'b0, qLast = 1'b0;
  logic [31:0] qData = '0;
  logic [5:0]  srcNode;
  logic [7:0]  blkSize, blkCount, pcmChan, midiByte;
  logic [2:0]  rateCode, midiPort;
  logic        pcmValid, labelErr, midiValid, lossPulse;
  logic [23:0] pcmSample;
  logic [ERRW-1:0] hdrErrCount;

  int  checks = 0, fails = 0, cycles = 0;
  int  expNext = 0, errModel = 0;
  bit  haveRef = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cip_am824_depacketizer #(.HDR_ERR_W(ERRW)) uut (
    .clk(clk), .rstN(rstN), .qValid(qValid), .qFirst(qFirst), .qLast(qLast),
    .qData(qData), .srcNode(srcNode), .blkSize(blkSize), .blkCount(blkCount),
    .rateCode(rateCode), .pcmValid(pcmValid), .pcmChan(pcmChan),
    .pcmSample(pcmSample), .labelErr(labelErr), .midiValid(midiValid),
    .midiPort(midiPort), .midiByte(midiByte), .lossPulse(lossPulse),
    .hdrErrCount(hdrErrCount));

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic putQ(logic [31:0] d, bit f, bit l);
    qValid = 1'b1; qData = d; qFirst = f; qLast = l;
    @(posedge clk);
    @(negedge clk);
    qValid = 1'b0; qFirst = 1'b0; qLast = 1'b0;
  endtask

  // bad: 0 none, 1 quadlet0 bits 15:8, 2 format, 3 quadlet1 bits 31:30; cut: no last mark
  task automatic sendPacket(int src, int dbs, int dbc, int nBlk, int rate,
                            int bad, int tail, bit cut);
    logic [31:0] h0, h1, d;
    int total;
    bit lossExp;
    total = nBlk * dbs + tail;
    h0 = {2'b00, src[5:0], dbs[7:0], 8'h00, dbc[7:0]};
    h1 = {2'b10, 6'h10, 5'b0, rate[2:0], 16'h1234};
    if (bad == 1) h0[12] = 1'b1;
    if (bad == 2) h1[29:24] = 6'h11;
    if (bad == 3) h1[31:30] = 2'b11;
    putQ(h0, 1'b1, 1'b0);
    chk("R3", "no strobe on header0", pcmValid | midiValid, 0);
    putQ(h1, 1'b0, (total == 0) && !cut);
    if (bad != 0) begin
      errModel = (errModel < ERRMAX) ? errModel + 1 : ERRMAX;
      chk("R3", "header error count", hdrErrCount, errModel);
      chk("R3", "no loss on bad header", lossPulse, 0);
    end else begin
      lossExp = haveRef && ((dbc & 255) != expNext);
      chk("R7", "loss pulse", lossPulse, lossExp);
      chk("R2", "source node", srcNode, src);
      chk("R2", "block size", blkSize, dbs);
      chk("R2", "block count", blkCount, dbc & 255);
      chk("R2", "rate code", rateCode, rate & 7);
      haveRef = 1;
      expNext = (dbc + nBlk) & 255;
    end
    for (int q = 0; q < total; q++) begin
      int k, s;
      bit isMidi, unk;
      logic [7:0]  mb;
      logic [23:0] smp;
      k = q / dbs; s = q % dbs;
      isMidi = (k % 3) != 0;
      unk    = ((k + s) % 5) == 4;
      mb     = 8'((dbc * 7 + k) & 255);
      smp    = 24'(((dbc << 16) ^ (k << 8) ^ s ^ 'h5a5a5a) & 'hffffff);
      if (s == 0) d = isMidi ? {8'h81, mb, 16'h0} : 32'h8000_0000;
      else        d = unk ? {8'h22, smp} : {8'h40, smp};
      putQ(d, 1'b0, (q == total - 1) && !cut);
      if (bad != 0) begin
        chk("R3", "dropped packet pcm", pcmValid, 0);
        chk("R3", "dropped packet midi", midiValid, 0);
      end else if (s == 0) begin
        chk("R4", "midi strobe", midiValid, isMidi);
        chk("R4", "no pcm on midi slot", pcmValid, 0);
        if (isMidi) begin
          chk("R4", "midi byte", midiByte, mb);
          chk("R4", "midi port", midiPort, (dbc + k) % 8);
        end
      end else begin
        chk("R5", "pcm strobe", pcmValid, 1);
        chk("R5", "pcm channel", pcmChan, s - 1);
        if (unk) begin
          chk("R6", "unknown label sample", pcmSample, 0);
          chk("R6", "label error", labelErr, 1);
        end else begin
          chk("R5", "pcm sample", pcmSample, smp);
          chk("R6", "no label error", labelErr, 0);
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int dbc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pcmValid", pcmValid, 0);
    chk("R1", "midiValid", midiValid, 0);
    chk("R1", "lossPulse", lossPulse, 0);
    chk("R1", "labelErr", labelErr, 0);
    chk("R1", "hdrErrCount", hdrErrCount, 0);
    chk("R1", "header fields", {srcNode, blkSize, blkCount, rateCode}, 0);
    chk("R1", "pcm fields", {pcmChan, pcmSample}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: first packet after reset never flags a loss; counts wrap past 255
    dbc = 250;
    for (int dbs = 1; dbs <= 5; dbs++) begin
      for (int nb = 0; nb <= 4; nb++) begin
        sendPacket(dbs * 5 + nb, dbs, dbc, nb, (dbs + nb) % 8, 0, 0, 1'b0);
        dbc = expNext;
        repeat (1) @(negedge clk);
      end
    end

    // R9: header-only packet predicts its own count
    sendPacket(3, 4, dbc, 0, 2, 0, 0, 1'b0);
    sendPacket(3, 4, dbc, 2, 2, 0, 0, 1'b0);
    dbc = expNext;

    // R7: discontinuity, then resync to the new count
    sendPacket(9, 3, (dbc + 3) & 255, 2, 4, 0, 0, 1'b0);
    dbc = expNext;
    sendPacket(9, 3, dbc, 2, 4, 0, 0, 1'b0);
    dbc = expNext;

    // R7: a trailing partial block is not counted
    sendPacket(7, 3, dbc, 2, 1, 0, 2, 1'b0);
    dbc = expNext;
    sendPacket(7, 3, dbc, 1, 1, 0, 0, 1'b0);
    dbc = expNext;

    // R8: stray quadlets between packets are ignored
    putQ({8'h40, 24'h123456}, 1'b0, 1'b0);
    chk("R8", "stray quadlet pcm", pcmValid, 0);
    putQ({8'h81, 24'h550000}, 1'b0, 1'b0);
    chk("R8", "stray quadlet midi", midiValid, 0);

    // R8: a packet cut short by a new first quadlet
    sendPacket(2, 4, dbc, 2, 5, 0, 1, 1'b1);
    dbc = expNext;
    sendPacket(2, 4, dbc, 2, 5, 0, 0, 1'b0);
    dbc = expNext;

    // R3: each rejection kind, published header untouched, prediction untouched
    for (int b = 1; b <= 3; b++) begin
      sendPacket(40, 3, 77, 2, 6, b, 0, 1'b0);
      chk("R3", "header kept after reject", blkCount, (dbc - 2) & 255);
      putQ({8'h40, 24'h0000aa}, 1'b0, 1'b0);
      chk("R8", "stray after rejected packet", pcmValid, 0);
    end
    sendPacket(2, 4, dbc, 1, 5, 0, 0, 1'b0);
    dbc = expNext;

    // R3: header-error counter saturates
    for (int b = 0; b < ERRMAX + 2; b++) begin
      sendPacket(1, 2, 10, 1, 0, 1 + (b % 3), 0, 1'b0);
    end
    chk("R3", "counter saturated", hdrErrCount, ERRMAX);

    // R2, R4, R5: packets still decode normally after the rejections
    sendPacket(63, 6, dbc, 5, 6, 0, 0, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule